// File: doc/BRIEF.md
# Configurable Line Edge Trigger with Pending Flags

This block watches a parameterised set of configurable event lines and turns selected edges into interrupt and CPU event requests. Each line can be armed for rising edges, falling edges or both. Line inputs may be asynchronous to the bus clock, so they are synchronized before any edge is detected. When an armed edge is seen and the line's interrupt is unmasked, the block latches a separate rising or falling pending flag. Each line has its own interrupt output, which stays active until software clears the flags.

Independently of the pending flags, an armed edge on a line whose event mask bit is set produces a one-cycle CPU event request on that line's event output. Software can also raise a trigger on a line through a self-clearing register bit, and this trigger behaves as a rising edge. The interrupt and event mask values come from outside the block as inputs. A small word-indexed register port with per-byte write enables holds the edge enables, the software trigger and the two pending registers.

Top module: `edge_trig_unit`

## Requirements
- R1: After reset every register (rising enable, falling enable, software trigger, rising pending, falling pending) reads 0, and `irq_o` and `cpu_evt_o` are all 0.
- R2: Each line passes through two flops, and an edge is taken from the last two synchronized samples. If `line_i` changes ahead of clock edge k, the line's `cpu_evt_o` bit is high for exactly the cycle between edges k+1 and k+2, and a pending flag sets at edge k+2.
- R3: The rising enable (word 0) and falling enable (word 1) of a line are independent. With both set, either edge triggers. With neither set, the line's edges have no effect.
- R4: Writing 1 to a bit of word 2 triggers that line as a rising edge, whatever its edge enables hold. The bit clears itself after one cycle, and word 2 always reads 0.
- R5: The rising pending flag (word 3) is set by an enabled hardware rising edge or by a software trigger. The falling pending flag (word 4) is set only by an enabled hardware falling edge.
- R6: A pending flag sets only if the line's `int_mask_i` bit is 1 at the triggering clock edge.
- R7: Writing 1 to a bit of word 3 or word 4 clears that flag, and writing 0 leaves it unchanged. If a set and a clear hit the same flag at the same edge, the flag ends up set.
- R8: `irq_o[i]` is 1 exactly while line i has its rising or falling pending flag set.
- R9: `cpu_evt_o[i]` is 1 during the cycle in which an enabled edge or a software trigger on line i is detected, if `evt_mask_i[i]` is 1. It does not depend on `int_mask_i` or on the pending flags.
- R10: A hardware edge detected at a clock edge where word 0 or word 1 is written (with any byte enable set) sets no pending flag. The CPU event request is still produced.
- R11: Byte enable bit j of `reg_be_i` controls write data bits 8j to 8j+7. Bits in disabled lanes keep their value, and a write-1 clear in a disabled lane has no effect.
- R12: Word indices 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_LINES | Configurable event lines, may be asynchronous |
| int_mask_i | input | NUM_LINES | Interrupt unmask per line (1 = unmasked) |
| evt_mask_i | input | NUM_LINES | CPU event unmask per line (1 = unmasked) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word index of the register |
| reg_be_i | input | 4 | Byte enables for the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | NUM_LINES | Interrupt request per line |
| cpu_evt_o | output | NUM_LINES | One-cycle CPU event request per line |

## Verification
The bound checker enforces these rules on every cycle:
- An interrupt output can rise only on a line whose interrupt was unmasked.
- An interrupt output can fall only after a bus write.
- The software trigger word always reads zero.
- Every event request can be traced to an input change two and three cycles earlier, or to a write one cycle earlier.

Some behaviours need specific stimulus and only the bench scenarios show them. These are the exact two-cycle latency of an edge, the independence of the two edge enables, the byte-lane merge, the suppression of pending flags during a write to the enable registers, and the set-over-clear collision. A behavioural model in the bench also tracks every register and output and compares them on each cycle.

// File: rtl/edge_trig_pkg.sv
package edge_trig_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = BUS_W / LANE_W;
  localparam int unsigned ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] ADDR_RISE_EN   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FALL_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SW_TRIG   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RISE_PEND = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FALL_PEND = 3'd4;
endpackage

// File: rtl/etu_sync.sv
module etu_sync #(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);
  // synchronizer stages plus one history flop for edge detection
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0][NUM_LINES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[DEPTH-2:0], line_i};
  end

  assign rise_o = pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];
  assign fall_o = ~pipe_q[DEPTH-2] & pipe_q[DEPTH-1];
endmodule

// File: rtl/etu_regs.sv
module etu_regs
  import edge_trig_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [NUM_LANES-1:0] reg_be_i,
  input  logic [BUS_W-1:0]     reg_wdata_i,
  output logic [BUS_W-1:0]     reg_rdata_o,
  input  logic [NUM_LINES-1:0] rise_pend_i,
  input  logic [NUM_LINES-1:0] fall_pend_i,
  output logic [NUM_LINES-1:0] rise_en_o,
  output logic [NUM_LINES-1:0] fall_en_o,
  output logic [NUM_LINES-1:0] sw_trig_o,
  output logic [NUM_LINES-1:0] rise_clr_o,
  output logic [NUM_LINES-1:0] fall_clr_o,
  output logic                 sel_wr_o
);
  logic [NUM_LINES-1:0] lane_mask, wr_bits;
  logic [NUM_LINES-1:0] rise_en_q, fall_en_q, sw_q;
  logic hit_rise, hit_fall, hit_sw, hit_rclr, hit_fclr;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
    assign lane_mask[i] = reg_be_i[i / LANE_W];
  end

  assign wr_bits  = reg_wdata_i[NUM_LINES-1:0] & lane_mask;
  assign hit_rise = reg_wr_i && (reg_addr_i == ADDR_RISE_EN);
  assign hit_fall = reg_wr_i && (reg_addr_i == ADDR_FALL_EN);
  assign hit_sw   = reg_wr_i && (reg_addr_i == ADDR_SW_TRIG);
  assign hit_rclr = reg_wr_i && (reg_addr_i == ADDR_RISE_PEND);
  assign hit_fclr = reg_wr_i && (reg_addr_i == ADDR_FALL_PEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      sw_q      <= '0;
    end else begin
      if (hit_rise) rise_en_q <= (rise_en_q & ~lane_mask) | wr_bits;
      if (hit_fall) fall_en_q <= (fall_en_q & ~lane_mask) | wr_bits;
      sw_q <= hit_sw ? wr_bits : '0;
    end
  end

  assign rise_en_o  = rise_en_q;
  assign fall_en_o  = fall_en_q;
  assign sw_trig_o  = sw_q;
  assign rise_clr_o = hit_rclr ? wr_bits : '0;
  assign fall_clr_o = hit_fclr ? wr_bits : '0;
  // edges landing on an enable write are not trusted
  assign sel_wr_o   = (hit_rise || hit_fall) && (|reg_be_i);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_RISE_EN:   reg_rdata_o[NUM_LINES-1:0] = rise_en_q;
      ADDR_FALL_EN:   reg_rdata_o[NUM_LINES-1:0] = fall_en_q;
      ADDR_RISE_PEND: reg_rdata_o[NUM_LINES-1:0] = rise_pend_i;
      ADDR_FALL_PEND: reg_rdata_o[NUM_LINES-1:0] = fall_pend_i;
      default:        reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/etu_pend.sv
module etu_pend #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] rise_edge_i,
  input  logic [NUM_LINES-1:0] fall_edge_i,
  input  logic [NUM_LINES-1:0] rise_en_i,
  input  logic [NUM_LINES-1:0] fall_en_i,
  input  logic [NUM_LINES-1:0] sw_trig_i,
  input  logic [NUM_LINES-1:0] int_mask_i,
  input  logic [NUM_LINES-1:0] evt_mask_i,
  input  logic [NUM_LINES-1:0] rise_clr_i,
  input  logic [NUM_LINES-1:0] fall_clr_i,
  input  logic                 sel_wr_i,
  output logic [NUM_LINES-1:0] rise_pend_o,
  output logic [NUM_LINES-1:0] fall_pend_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic [NUM_LINES-1:0] cpu_evt_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rise_trig, fall_trig, rise_set, fall_set;
    logic rp_q, fp_q;

    assign rise_trig = rise_edge_i[i] & rise_en_i[i];
    assign fall_trig = fall_edge_i[i] & fall_en_i[i];
    assign rise_set  = int_mask_i[i] & (sw_trig_i[i] | (rise_trig & ~sel_wr_i));
    assign fall_set  = int_mask_i[i] & fall_trig & ~sel_wr_i;

    // set has priority over a same-cycle write-1 clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rp_q <= 1'b0;
        fp_q <= 1'b0;
      end else begin
        rp_q <= rise_set | (rp_q & ~rise_clr_i[i]);
        fp_q <= fall_set | (fp_q & ~fall_clr_i[i]);
      end
    end

    assign rise_pend_o[i] = rp_q;
    assign fall_pend_o[i] = fp_q;
    assign irq_o[i]       = rp_q | fp_q;
    assign cpu_evt_o[i]   = evt_mask_i[i] & (rise_trig | fall_trig | sw_trig_i[i]);
  end
endmodule

// File: rtl/edge_trig_unit.sv
module edge_trig_unit
  import edge_trig_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] int_mask_i,
  input  logic [NUM_LINES-1:0] evt_mask_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [NUM_LANES-1:0] reg_be_i,
  input  logic [BUS_W-1:0]     reg_wdata_i,
  output logic [BUS_W-1:0]     reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic [NUM_LINES-1:0] cpu_evt_o
);
  if (NUM_LINES == 0 || NUM_LINES > BUS_W || SYNC_STAGES < 1) begin : g_bad_cfg
    $error("edge_trig_unit: unsupported NUM_LINES or SYNC_STAGES");
  end

  logic [NUM_LINES-1:0] rise_edge, fall_edge;
  logic [NUM_LINES-1:0] rise_en, fall_en, sw_trig;
  logic [NUM_LINES-1:0] rise_clr, fall_clr, rise_pend, fall_pend;
  logic                 sel_wr;

  etu_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .rise_o (rise_edge),
    .fall_o (fall_edge)
  );

  etu_regs #(.NUM_LINES(NUM_LINES)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_be_i    (reg_be_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .rise_pend_i (rise_pend),
    .fall_pend_i (fall_pend),
    .rise_en_o   (rise_en),
    .fall_en_o   (fall_en),
    .sw_trig_o   (sw_trig),
    .rise_clr_o  (rise_clr),
    .fall_clr_o  (fall_clr),
    .sel_wr_o    (sel_wr)
  );

  etu_pend #(.NUM_LINES(NUM_LINES)) i_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_edge_i (rise_edge),
    .fall_edge_i (fall_edge),
    .rise_en_i   (rise_en),
    .fall_en_i   (fall_en),
    .sw_trig_i   (sw_trig),
    .int_mask_i  (int_mask_i),
    .evt_mask_i  (evt_mask_i),
    .rise_clr_i  (rise_clr),
    .fall_clr_i  (fall_clr),
    .sel_wr_i    (sel_wr),
    .rise_pend_o (rise_pend),
    .fall_pend_o (fall_pend),
    .irq_o       (irq_o),
    .cpu_evt_o   (cpu_evt_o)
  );
endmodule

// File: rtl/edge_trig_unit_chk.sv
module edge_trig_unit_chk
  import edge_trig_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] line_i,
  input logic [NUM_LINES-1:0] int_mask_i,
  input logic                 reg_wr_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [BUS_W-1:0]     reg_rdata_o,
  input logic [NUM_LINES-1:0] irq_o,
  input logic [NUM_LINES-1:0] cpu_evt_o
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd3);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_QUIET_IN_RESET: assert (irq_o == '0 && cpu_evt_o == '0); // R1
    end
  end

  AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> ((irq_o & ~$past(irq_o) & ~$past(int_mask_i)) == '0)); // R6

  AST_IRQ_DROP_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && ((~irq_o & $past(irq_o)) != '0)) |-> $past(reg_wr_i)); // R7

  AST_SW_WORD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_SW_TRIG) |-> (reg_rdata_o == '0)); // R4

  AST_EVT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && (|cpu_evt_o)) |-> (($past(line_i, 2) != $past(line_i, 3)) || $past(reg_wr_i))); // R2
endmodule

bind edge_trig_unit edge_trig_unit_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_i      (line_i),
  .int_mask_i  (int_mask_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .cpu_evt_o   (cpu_evt_o)
);

// File: tb/test_edge_trig_unit.sv
module test_edge_trig_unit;
  import edge_trig_pkg::*;
  localparam int unsigned N = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] line, imask, emask;
  logic wr;
  logic [ADDR_W-1:0] addr;
  logic [NUM_LANES-1:0] be;
  logic [BUS_W-1:0] wdata, rdata;
  logic [N-1:0] irq, evt;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_trig_unit #(.NUM_LINES(N)) i_edge_trig_unit (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .int_mask_i(imask), .evt_mask_i(emask),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_be_i(be), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .cpu_evt_o(evt)
  );

  // behavioural reference
  logic [N-1:0] m_s1, m_s2, m_s3, m_ren, m_fen, m_sw, m_rp, m_fp;
  logic [N-1:0] t_rh, t_fh, t_wb, t_rs, t_fs;
  logic t_blk;

  function automatic logic [N-1:0] lanes(input logic [NUM_LANES-1:0] b);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = b[i/8];
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    case (a)
      3'd0: return BUS_W'(m_ren);
      3'd1: return BUS_W'(m_fen);
      3'd3: return BUS_W'(m_rp);
      3'd4: return BUS_W'(m_fp);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_ren = '0; m_fen = '0;
      m_sw = '0; m_rp = '0; m_fp = '0;
    end else begin
      t_rh  = m_s2 & ~m_s3 & m_ren;
      t_fh  = ~m_s2 & m_s3 & m_fen;
      t_blk = wr && (addr == 3'd0 || addr == 3'd1) && (be != '0);
      t_wb  = wdata[N-1:0] & lanes(be);
      t_rs  = imask & (m_sw | (t_blk ? '0 : t_rh));
      t_fs  = imask & (t_blk ? '0 : t_fh);
      m_rp  = t_rs | (m_rp & ~((wr && addr == 3'd3) ? t_wb : '0));
      m_fp  = t_fs | (m_fp & ~((wr && addr == 3'd4) ? t_wb : '0));
      if (wr && addr == 3'd0) m_ren = (m_ren & ~lanes(be)) | t_wb;
      if (wr && addr == 3'd1) m_fen = (m_fen & ~lanes(be)) | t_wb;
      m_sw = (wr && addr == 3'd2) ? t_wb : '0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = line;
    end
  end

  task automatic check(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check("R8 irq vs model", BUS_W'(irq), BUS_W'(m_rp | m_fp));
      check("R9 cpu event vs model", BUS_W'(evt),
            BUS_W'((((m_s2 & ~m_s3 & m_ren) | (~m_s2 & m_s3 & m_fen) | m_sw) & emask)));
      check("R12 read data vs model", rdata, exp_read(addr));
    end
  end

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d,
                           input logic [NUM_LANES-1:0] b);
    @(negedge clk); #1;
    wr = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk); #1;
    wr = 1'b0; be = '0;
  endtask

  task automatic expect_reg(input string tag, input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] e);
    @(negedge clk); #1;
    addr = a;
    #1 check(tag, rdata, e);
  endtask

  task automatic finish_up;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_up();
  end

  initial begin
    int cnt;
    rst_n = 1'b1; line = '0; wr = 1'b0; addr = '0; be = '0; wdata = '0;
    imask = '1; emask = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) expect_reg("R1 reset register", ADDR_W'(a), '0);
    check("R1 reset irq", BUS_W'(irq), '0);
    check("R1 reset event", BUS_W'(evt), '0);

    // R3 / R5 independent edges
    bus_write(3'd0, 32'h0005, 4'hF);
    bus_write(3'd1, 32'h0006, 4'hF);
    @(negedge clk); #1 line = 16'h0007;
    repeat (4) @(negedge clk);
    expect_reg("R3 rising pend after rise", 3'd3, 32'h0005);
    expect_reg("R5 no falling pend on rise", 3'd4, 32'h0000);
    @(negedge clk); #1 line = 16'h0000;
    repeat (4) @(negedge clk);
    expect_reg("R3 falling pend after fall", 3'd4, 32'h0006);
    check("R8 irq either flag", BUS_W'(irq), 32'h0007);

    // R7 write-one-to-clear
    bus_write(3'd3, 32'h0000, 4'hF);
    expect_reg("R7 write 0 keeps flag", 3'd3, 32'h0005);
    bus_write(3'd3, 32'h0001, 4'hF);
    expect_reg("R7 write 1 clears flag", 3'd3, 32'h0004);
    check("R8 irq after partial clear", BUS_W'(irq), 32'h0006);
    bus_write(3'd4, 32'hFFFF, 4'hF);
    bus_write(3'd3, 32'hFFFF, 4'hF);
    check("R8 irq after full clear", BUS_W'(irq), 32'h0000);

    // R2 latency of the event request
    @(negedge clk); #1 emask = 16'h0001; line[0] = 1'b1;
    @(negedge clk); #1 check("R2 no event after 1 edge", BUS_W'(evt[0]), 32'h0);
    @(negedge clk); #1 check("R2 event after 2 edges", BUS_W'(evt[0]), 32'h1);
    @(negedge clk); #1 check("R2 event one cycle only", BUS_W'(evt[0]), 32'h0);
    check("R2 pending set at third edge", BUS_W'(irq), 32'h0001);
    bus_write(3'd3, 32'h0001, 4'hF);
    @(negedge clk); #1 line[0] = 1'b0; emask = '0;
    repeat (4) @(negedge clk);

    // R6 / R9 masked interrupt still yields event
    bus_write(3'd0, 32'h000D, 4'hF);
    @(negedge clk); #1 imask = 16'hFFF7; emask = 16'h0008; line[3] = 1'b1;
    cnt = 0;
    repeat (5) begin
      @(negedge clk); #1;
      if (evt[3]) cnt++;
    end
    check("R9 single event pulse while masked", 32'(cnt), 32'd1);
    expect_reg("R6 masked line sets no pending", 3'd3, 32'h0000);
    @(negedge clk); #1 imask = '1; emask = '0;

    // R4 / R5 software trigger
    bus_write(3'd2, 32'h0020, 4'hF);
    expect_reg("R4 software word reads zero", 3'd2, 32'h0000);
    expect_reg("R5 software sets rising pend", 3'd3, 32'h0020);
    expect_reg("R5 software leaves falling pend", 3'd4, 32'h0000);
    bus_write(3'd3, 32'h0020, 4'hF);

    // R11 byte lanes
    bus_write(3'd0, 32'hFFFF, 4'b0010);
    expect_reg("R11 only lane 1 written", 3'd0, 32'hFF0D);
    bus_write(3'd3, 32'h0000, 4'hF);
    bus_write(3'd0, 32'h00C0, 4'hF);

    // R10 edge on enable-register write cycle
    @(negedge clk); #1 emask = 16'h0040; line[6] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1;
    check("R10 event still produced", BUS_W'(evt[6]), 32'h1);
    wr = 1'b1; addr = 3'd1; wdata = 32'h0006; be = 4'hF;
    @(negedge clk); #1 wr = 1'b0; be = '0;
    expect_reg("R10 pending suppressed", 3'd3, 32'h0000);
    check("R10 no irq", BUS_W'(irq), 32'h0000);
    @(negedge clk); #1 emask = '0;

    // R7 set wins over clear
    @(negedge clk); #1 line[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1;
    wr = 1'b1; addr = 3'd3; wdata = 32'h0080; be = 4'hF;
    @(negedge clk); #1 wr = 1'b0; be = '0;
    expect_reg("R7 set wins collision", 3'd3, 32'h0080);
    check("R8 irq on collided line", BUS_W'(irq), 32'h0080);
    bus_write(3'd3, 32'h0080, 4'hF);
    expect_reg("R7 later clear works", 3'd3, 32'h0000);

    // R12 unmapped words
    bus_write(3'd5, 32'hFFFF_FFFF, 4'hF);
    expect_reg("R12 unmapped reads zero", 3'd5, 32'h0);
    expect_reg("R12 rising enable untouched", 3'd0, 32'h00C0);
    expect_reg("R12 falling enable untouched", 3'd1, 32'h0006);

    // R3 line with no enable
    @(negedge clk); #1 emask = 16'h0100; line[8] = 1'b1;
    repeat (4) @(negedge clk);
    #1 line[8] = 1'b0;
    repeat (4) @(negedge clk);
    expect_reg("R3 unarmed line no rising pend", 3'd3, 32'h0);
    expect_reg("R3 unarmed line no falling pend", 3'd4, 32'h0);
    check("R3 unarmed line no irq", BUS_W'(irq), 32'h0);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule